// File: doc/BRIEF.md
# Dual Fan Speed Selector with PWM Drive

This block picks a 4-bit speed code for each of two cooling fans and turns that code into a pulse-width-modulated drive signal. Each fan has three programmed codes: a minimum (normal) code, an alarm code and a hot-plug code. A layered arbitration chooses between them. The inputs to that arbitration are software force bits, masked system events and a per-fan choice of whether alarm or hot-plug speed wins when both are asked for. A fan that is not marked installed is never driven. Full speed overrides everything else.

The PWM generator for each fan divides the system clock with a prescaler. A two-bit frequency field sets the divider, and each PWM period has fifteen steps. The duty is the code divided by fifteen, so code 15 gives a constant high level and code 0 gives a constant low level. A new code is taken up only at the start of a period, so a change never produces a runt pulse. The output is high when the fan should be powered. An external open-drain stage inverts or buffers it as the board requires.

Top module: `fan_speed_sel`

## Requirements
- R1: After a synchronous active-low reset, every `sel_code` lane is 0 and every `pwm_out` bit is low.
- R2: For an installed fan with monitoring enabled and no force bit or enabled event, the selected code is the low nibble (bits 3:0) of that fan's `speed_cfg` byte.
- R3: A fan whose `installed` bit is 0 has selected code 0 and a constantly low `pwm_out`, whatever its other inputs.
- R4: An installed fan with its `force_full` bit set has code 15 and a constantly high `pwm_out`, overriding every alarm and hot-plug request.
- R5: The alarm code is the high nibble (bits 7:4) of the fan's `speed_cfg` byte. The `force_alarm` bit of a fan selects it.
- R6: When `mon_en` is 0, every installed fan that is not forced to full speed runs at its alarm code.
- R7: Any tach-limit flag, fault flag, temperature alarm, general-purpose alarm or cascaded-fault flag requests alarm speed for fan i only when fan i's enable bit for that event (bit i of the matching `en_*` port) is 1. When the enable bit is 0, the event has no effect on that fan.
- R8: A fan whose `en_unplug` bit is set goes to its hot-plug code, the low nibble (bits 3:0) of its `fan_cfg` byte, while any other fan's `ev_unplug` bit is 1. A fan's own unplug bit does not affect it.
- R9: The `force_hp` bit of a fan selects its hot-plug code.
- R10: When alarm and hot-plug speed are both requested for a fan, its `hp_first` bit picks the result: 1 selects the hot-plug code and 0 selects the alarm code.
- R11: In steady state `pwm_out` is high for exactly `code` of every 15 PWM steps.
- R12: A change of selected code changes the PWM duty only from the start of the next PWM period.
- R13: One PWM step lasts `BASE_DIV << fsel` clock cycles. Here `fsel` is bits 5:4 of the fan's `fan_cfg` byte, so a period is 15 times that.
- R14: `sel_code` follows its inputs with one clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_cfg | input | N_FANS x 8 | Per fan: bits 3:0 minimum code, bits 7:4 alarm code |
| fan_cfg | input | N_FANS x 8 | Per fan: bits 3:0 hot-plug code, bits 5:4 PWM frequency select |
| installed | input | N_FANS | Fan is expected to be present and may be driven |
| mon_en | input | 1 | Fan monitoring enabled; 0 forces alarm speed |
| force_alarm | input | N_FANS | Software request for alarm speed |
| force_hp | input | N_FANS | Software request for hot-plug speed |
| force_full | input | N_FANS | Software request for full speed |
| hp_first | input | N_FANS | 1: hot-plug beats alarm; 0: alarm beats hot-plug |
| ev_tach | input | N_FANS | Tach limit violation flags, one per fan |
| ev_fault | input | N_FANS | Fault input flags, one per fan |
| ev_temp | input | 1 | Temperature alarm event |
| ev_gpio | input | 1 | General-purpose input alarm event |
| ev_cfault | input | 1 | Cascaded fault event |
| ev_unplug | input | N_FANS | Fan removed flags, one per fan |
| en_tach | input | N_FANS | Per-fan enable for tach events |
| en_fault | input | N_FANS | Per-fan enable for fault events |
| en_temp | input | N_FANS | Per-fan enable for temperature events |
| en_gpio | input | N_FANS | Per-fan enable for general-purpose events |
| en_cfault | input | N_FANS | Per-fan enable for cascaded fault events |
| en_unplug | input | N_FANS | Per-fan enable for the other-fan-removed response |
| pwm_out | output | N_FANS | PWM drive, high = fan powered |
| sel_code | output | N_FANS x 4 | Currently selected speed code per fan |

## Verification
The selector is driven through one source at a time: the quiet state, each force bit, monitoring off, and every event class with its enable both set and cleared. This separates a missing mask from a wrong code path. Sources are then combined: alarm with hot-plug under both priority settings, full speed on top of both, and an uninstalled fan with everything asserted. These combinations expose ordering faults in the arbitration. The two fans run at different frequency selects and codes, so high-time counts over whole periods tell duty errors apart from prescaler errors. Codes are changed in the middle of a period to show whether the duty is taken up only at the period start.

// File: rtl/fss_pkg.sv
// Shared types and constants for the dual fan speed selector.
// Assumes 4-bit speed codes and a 15-step PWM period (duty = code/15).
package fss_pkg;
    localparam int CODE_W    = 4;
    localparam int PWM_STEPS = 15;
    typedef logic [CODE_W-1:0] speed_code_t;
    localparam speed_code_t CODE_OFF  = speed_code_t'(0);
    localparam speed_code_t CODE_FULL = speed_code_t'(PWM_STEPS);
endpackage

// File: rtl/fss_arbiter.sv
// Speed code arbiter for one fan.
// Picks off / full / alarm / hot-plug / minimum in that precedence. The
// hp_first bit settles a tie between alarm and hot-plug. The result is
// registered. Assumes the alarm and hot-plug requests arrive already
// masked for this fan.
module fss_arbiter
    import fss_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        installed,
    input  logic        force_full,
    input  logic        alarm_req,
    input  logic        hp_req,
    input  logic        hp_first,
    input  speed_code_t min_code,
    input  speed_code_t alarm_code,
    input  speed_code_t hp_code,
    output speed_code_t code_q
);
    speed_code_t code_d;

    // Layered choice of the next speed code.
    always_comb begin
        if (!installed)
            code_d = CODE_OFF;
        else if (force_full)
            code_d = CODE_FULL;
        else if (alarm_req && hp_req)
            code_d = hp_first ? hp_code : alarm_code;
        else if (alarm_req)
            code_d = alarm_code;
        else if (hp_req)
            code_d = hp_code;
        else
            code_d = min_code;
    end

    // Register the selected code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= CODE_OFF;
        else        code_q <= code_d;
    end

    // R3
    off_when_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !installed |=> code_q == CODE_OFF);
    // R4
    full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (installed && force_full) |=> code_q == CODE_FULL);
    // R10
    tie_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (installed && !force_full && alarm_req && hp_req && !hp_first)
        |=> code_q == $past(alarm_code));
endmodule

// File: rtl/fss_pwm.sv
// PWM generator for one fan.
// A prescaler of (BASE_DIV << fsel) clocks advances a 15-step counter.
// The output is high while step < duty. The duty is reloaded from code_in
// only when the counter wraps, so each period uses a single duty.
// Assumes BASE_DIV << 3 fits in PRE_W bits.
module fss_pwm
    import fss_pkg::*;
#(
    parameter int BASE_DIV = 33333,
    parameter int PRE_W    = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  speed_code_t code_in,
    input  logic [1:0]  fsel,
    output logic        pwm_out
);
    localparam speed_code_t LAST_STEP = speed_code_t'(PWM_STEPS - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;
    speed_code_t      step;
    speed_code_t      duty_q;

    assign pre_lim = (PRE_W'(BASE_DIV) << fsel) - PRE_W'(1);
    assign tick    = (pre_cnt >= pre_lim);

    // Prescaler: one tick every BASE_DIV << fsel clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (tick) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // Step counter and period-boundary duty reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= '0;
            duty_q <= CODE_OFF;
        end else if (tick) begin
            if (step == LAST_STEP) begin
                step   <= '0;
                duty_q <= code_in;
            end else begin
                step <= step + speed_code_t'(1);
            end
        end
    end

    assign pwm_out = (step < duty_q);

    // R12
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && step == LAST_STEP) |=> $stable(duty_q));
    // R13
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(step));
    // R11
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q == CODE_FULL |-> pwm_out);
    // R11
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q == CODE_OFF |-> !pwm_out);
endmodule

// File: rtl/fan_speed_sel.sv
// Dual fan speed selector with PWM drive (top).
// Masks the system events per fan, arbitrates a speed code per fan and
// drives one PWM generator per fan. Assumes all event flags are already
// synchronous to clk and qualified by their own detectors.
module fan_speed_sel
    import fss_pkg::*;
#(
    parameter int N_FANS   = 2,
    parameter int BASE_DIV = 33333,
    parameter int PRE_W    = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_FANS-1:0][7:0]        speed_cfg,
    input  logic [N_FANS-1:0][7:0]        fan_cfg,
    input  logic [N_FANS-1:0]             installed,
    input  logic                          mon_en,
    input  logic [N_FANS-1:0]             force_alarm,
    input  logic [N_FANS-1:0]             force_hp,
    input  logic [N_FANS-1:0]             force_full,
    input  logic [N_FANS-1:0]             hp_first,
    input  logic [N_FANS-1:0]             ev_tach,
    input  logic [N_FANS-1:0]             ev_fault,
    input  logic                          ev_temp,
    input  logic                          ev_gpio,
    input  logic                          ev_cfault,
    input  logic [N_FANS-1:0]             ev_unplug,
    input  logic [N_FANS-1:0]             en_tach,
    input  logic [N_FANS-1:0]             en_fault,
    input  logic [N_FANS-1:0]             en_temp,
    input  logic [N_FANS-1:0]             en_gpio,
    input  logic [N_FANS-1:0]             en_cfault,
    input  logic [N_FANS-1:0]             en_unplug,
    output logic [N_FANS-1:0]             pwm_out,
    output logic [N_FANS-1:0][CODE_W-1:0] sel_code
);
    logic       any_tach;
    logic       any_fault;
    logic [N_FANS-1:0] alarm_req;
    logic [N_FANS-1:0] hp_req;

    assign any_tach  = |ev_tach;
    assign any_fault = |ev_fault;

    for (genvar i = 0; i < N_FANS; i++) begin : g_fan
        localparam logic [N_FANS-1:0] OTHERS = ~(N_FANS'(1) << i);

        // Per-fan masked alarm and hot-plug requests.
        assign alarm_req[i] = force_alarm[i] | ~mon_en
                            | (en_tach[i]   & any_tach)
                            | (en_fault[i]  & any_fault)
                            | (en_temp[i]   & ev_temp)
                            | (en_gpio[i]   & ev_gpio)
                            | (en_cfault[i] & ev_cfault);
        assign hp_req[i]    = force_hp[i] | (en_unplug[i] & |(ev_unplug & OTHERS));

        fss_arbiter u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .installed  (installed[i]),
            .force_full (force_full[i]),
            .alarm_req  (alarm_req[i]),
            .hp_req     (hp_req[i]),
            .hp_first   (hp_first[i]),
            .min_code   (speed_cfg[i][3:0]),
            .alarm_code (speed_cfg[i][7:4]),
            .hp_code    (fan_cfg[i][3:0]),
            .code_q     (sel_code[i])
        );

        fss_pwm #(.BASE_DIV(BASE_DIV), .PRE_W(PRE_W)) u_pwm (
            .clk     (clk),
            .rst_n   (rst_n),
            .code_in (sel_code[i]),
            .fsel    (fan_cfg[i][5:4]),
            .pwm_out (pwm_out[i])
        );

        // R3
        absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!installed[i] && $past(!installed[i]) && sel_code[i] == CODE_OFF)
            |=> !pwm_out[i] || $past(pwm_out[i]));
        // R6
        mon_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mon_en && installed[i] && !force_full[i] && !hp_req[i])
            |=> sel_code[i] == $past(speed_cfg[i][7:4]));
    end
endmodule

// File: tb/tb_fan_speed_sel.sv
// Bench for fan_speed_sel: behavioural reference model compared every cycle,
// plus directed checks tagged by requirement.
module tb_fan_speed_sel;
    localparam int NF = 2;
    localparam int BD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NF-1:0][7:0] speed_cfg = '0;
    logic [NF-1:0][7:0] fan_cfg = '0;
    logic [NF-1:0] installed = '0, force_alarm = '0, force_hp = '0, force_full = '0, hp_first = '0;
    logic mon_en = 1'b0, ev_temp = 1'b0, ev_gpio = 1'b0, ev_cfault = 1'b0;
    logic [NF-1:0] ev_tach = '0, ev_fault = '0, ev_unplug = '0;
    logic [NF-1:0] en_tach = '0, en_fault = '0, en_temp = '0, en_gpio = '0, en_cfault = '0, en_unplug = '0;
    logic [NF-1:0] pwm_out;
    logic [NF-1:0][3:0] sel_code;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;
    int m_pre[NF], m_step[NF], m_duty[NF], m_sel[NF];

    always #4 clk = ~clk;

    fan_speed_sel #(.N_FANS(NF), .BASE_DIV(BD), .PRE_W(20)) dut (
        .clk(clk), .rst_n(rst_n), .speed_cfg(speed_cfg), .fan_cfg(fan_cfg),
        .installed(installed), .mon_en(mon_en), .force_alarm(force_alarm),
        .force_hp(force_hp), .force_full(force_full), .hp_first(hp_first),
        .ev_tach(ev_tach), .ev_fault(ev_fault), .ev_temp(ev_temp), .ev_gpio(ev_gpio),
        .ev_cfault(ev_cfault), .ev_unplug(ev_unplug), .en_tach(en_tach),
        .en_fault(en_fault), .en_temp(en_temp), .en_gpio(en_gpio),
        .en_cfault(en_cfault), .en_unplug(en_unplug), .pwm_out(pwm_out),
        .sel_code(sel_code));

    // Expected code from the requirement text (R2-R10).
    function automatic int ref_code(int i);
        bit alarm, hp, other_gone;
        other_gone = 1'b0;
        for (int j = 0; j < NF; j++) if (j != i && ev_unplug[j]) other_gone = 1'b1;
        alarm = force_alarm[i] || !mon_en || (en_tach[i] && ev_tach != 0)
             || (en_fault[i] && ev_fault != 0) || (en_temp[i] && ev_temp)
             || (en_gpio[i] && ev_gpio) || (en_cfault[i] && ev_cfault);
        hp = force_hp[i] || (en_unplug[i] && other_gone);
        if (!installed[i]) return 0;
        if (force_full[i]) return 15;
        if (alarm && hp) return hp_first[i] ? int'(fan_cfg[i][3:0]) : int'(speed_cfg[i][7:4]);
        if (alarm) return int'(speed_cfg[i][7:4]);
        if (hp) return int'(fan_cfg[i][3:0]);
        return int'(speed_cfg[i][3:0]);
    endfunction

    // Reference model advance (R11-R14 timing).
    always @(posedge clk) begin
        for (int i = 0; i < NF; i++) begin
            if (!rst_n) begin
                m_pre[i] = 0; m_step[i] = 0; m_duty[i] = 0; m_sel[i] = 0;
            end else begin
                int lim;
                bit tk;
                lim = (BD << fan_cfg[i][5:4]) - 1;
                tk = (m_pre[i] >= lim);
                m_pre[i] = tk ? 0 : m_pre[i] + 1;
                if (tk) begin
                    if (m_step[i] == 14) begin m_step[i] = 0; m_duty[i] = m_sel[i]; end
                    else m_step[i] = m_step[i] + 1;
                end
                m_sel[i] = ref_code(i);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int i = 0; i < NF; i++) begin
                chk(cur_req, int'(sel_code[i]), m_sel[i]);
                chk(cur_req, int'(pwm_out[i]), (m_step[i] < m_duty[i]) ? 1 : 0);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic count_high(int fan, int ncyc, output int hi);
        hi = 0;
        repeat (ncyc) begin
            @(negedge clk);
            if (pwm_out[fan]) hi++;
        end
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        cyc(3);
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(sel_code), 0);
        chk("R1", int'(pwm_out), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        speed_cfg[0] = 8'hA3; speed_cfg[1] = 8'hC6;
        fan_cfg[0] = 8'h07;   fan_cfg[1] = 8'h19;
        installed = 2'b11; mon_en = 1'b1;
        cmp_on = 1'b1;
        cur_req = "R2"; cyc(3);
        chk("R2", int'(sel_code[0]), 3); chk("R2", int'(sel_code[1]), 6);
        cyc(130);
        cur_req = "R11";
        count_high(0, 60, hi);  chk("R11", hi, 2 * 3 * 2);
        cur_req = "R13";
        count_high(1, 120, hi); chk("R13", hi, 2 * 6 * 4);
        cur_req = "R14";
        speed_cfg[0] = 8'hA5;
        @(negedge clk); chk("R14", int'(sel_code[0]), 3);
        @(negedge clk); chk("R14", int'(sel_code[0]), 5);
        @(posedge clk); #2;
        cur_req = "R12";
        cyc(7); speed_cfg[0] = 8'hA9; cyc(11); speed_cfg[0] = 8'hA2; cyc(90);
        speed_cfg[0] = 8'hA3;
        cur_req = "R5"; force_alarm = 2'b01; cyc(2);
        chk("R5", int'(sel_code[0]), 10); chk("R5", int'(sel_code[1]), 6); cyc(70);
        force_alarm = '0;
        cur_req = "R6"; mon_en = 1'b0; cyc(2);
        chk("R6", int'(sel_code[0]), 10); chk("R6", int'(sel_code[1]), 12); cyc(40);
        mon_en = 1'b1;
        cur_req = "R7";
        ev_tach = 2'b10; en_tach = 2'b01; cyc(2);
        chk("R7", int'(sel_code[0]), 10); chk("R7", int'(sel_code[1]), 6);
        en_tach = 2'b00; cyc(2);
        chk("R7", int'(sel_code[0]), 3); ev_tach = '0;
        ev_temp = 1'b1; en_temp = 2'b10; cyc(2); chk("R7", int'(sel_code[1]), 12);
        en_temp = '0; cyc(2); chk("R7", int'(sel_code[1]), 6); ev_temp = 1'b0;
        ev_gpio = 1'b1; en_gpio = 2'b01; cyc(2); chk("R7", int'(sel_code[0]), 10);
        ev_gpio = 1'b0; en_gpio = '0;
        ev_cfault = 1'b1; en_cfault = 2'b10; cyc(2); chk("R7", int'(sel_code[1]), 12);
        ev_cfault = 1'b0; en_cfault = '0;
        ev_fault = 2'b01; en_fault = 2'b10; cyc(2);
        chk("R7", int'(sel_code[1]), 12); chk("R7", int'(sel_code[0]), 3);
        ev_fault = '0; en_fault = '0; cyc(30);
        cur_req = "R8"; ev_unplug = 2'b01; en_unplug = 2'b11; cyc(2);
        chk("R8", int'(sel_code[1]), 9); chk("R8", int'(sel_code[0]), 3);
        en_unplug = 2'b00; cyc(2); chk("R8", int'(sel_code[1]), 6);
        ev_unplug = '0; cyc(20);
        cur_req = "R9"; force_hp = 2'b01; cyc(2); chk("R9", int'(sel_code[0]), 7); cyc(40);
        cur_req = "R10"; force_hp = 2'b11; force_alarm = 2'b11; hp_first = 2'b01; cyc(2);
        chk("R10", int'(sel_code[0]), 7); chk("R10", int'(sel_code[1]), 12);
        hp_first = 2'b10; cyc(2);
        chk("R10", int'(sel_code[0]), 10); chk("R10", int'(sel_code[1]), 9); cyc(40);
        cur_req = "R4"; force_full = 2'b11; cyc(2);
        chk("R4", int'(sel_code[0]), 15); chk("R4", int'(sel_code[1]), 15);
        cyc(130); count_high(1, 120, hi); chk("R4", hi, 120);
        cur_req = "R3"; installed = 2'b00; cyc(2);
        chk("R3", int'(sel_code), 0);
        cyc(130); count_high(0, 60, hi); chk("R3", hi, 0);
        cmp_on = 1'b0;
        finish_run();
    end
endmodule